// File: doc/BRIEF.md
# Timebase and Timer-Pulse Generator

This block is the shared time reference of a packet-processing engine. A 56-bit count advances on every reference-clock cycle (nominally 19.2 MHz). Three coarse timestamps are cut from that one count, each shifted right by its own programmable amount, so they stay consistent with one another. A shift of 14 gives steps of roughly 853 us, and a shift of 24 gives steps of roughly 0.87 s. The logging timestamp can instead follow an older millisecond counter.

The block also divides the reference clock into a common timer clock. The divider is programmed with the ratio minus one, so a field of 191 turns 19.2 MHz into 100 kHz. Three pulse generators run from that timer clock. Each emits a one-cycle strobe at a granularity of 10 us, 100 us, 1 ms or 10 ms, for timeout logic elsewhere. Configuration arrives through a small write-only register port.

Top module: `timebase_gen`

## Requirements
- R1: `base_count_o` is 0 during reset and increases by exactly 1 on every clock edge after reset is released.
- R2: Register address 1 holds the timestamp configuration: log shift in bits [5:0], log select in bit 6, tag shift in bits [13:8], translation shift in bits [21:16]. `ts_tag_o` equals the low TS_W bits of the base count shifted right by the tag shift, and `ts_xlat_o` does the same with the translation shift.
- R3: With log select at 1, `ts_log_o` is the base count shifted right by the log shift. With log select at 0, `ts_log_o` is a millisecond count that advances once every LEGACY_MS_CYCLES clock cycles from reset, so it equals the base count divided by LEGACY_MS_CYCLES.
- R4: Register address 2 holds the divider ratio minus one in bits [DIV_W-1:0] and the enable in bit 16. When enabled, the timer clock ticks once every (field + 1) reference cycles.
- R5: Register address 0 holds one 2-bit granularity field per generator g, in bits [2g+1:2g]. The encodings are 0 = 1 timer tick (10 us), 1 = 10 ticks (100 us), 2 = 100 ticks (1 ms) and 3 = 1000 ticks (10 ms). Each generator drives its bit of `pulse_o` high for one cycle, once per (ratio field + 1) x ticks reference cycles.
- R6: While the divider is disabled, `pulse_o` stays 0 and every generator holds its count at zero.
- R7: The divider phase restarts at zero when the enable goes from 0 to 1. If the enabling write is captured on edge E, generator g's first pulse is visible N x P cycles later, where N is the ratio field plus one and P is that generator's tick count.
- R8: A write to address 2 while the divider is enabled leaves the ratio unchanged. Its enable bit still takes effect.
- R9: A write that changes a generator's granularity field restarts that generator's count. Generators whose field does not change keep their phase.
- R10: After reset all shift fields, the log select, all granularity fields and the divider enable are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 granularity, 1 timestamp config, 2 divider) |
| wr_data_i | input | 32 | Register write data |
| base_count_o | output | CNT_W (56) | Free-running base count |
| ts_log_o | output | TS_W (32) | Logging timestamp |
| ts_tag_o | output | TS_W (32) | Tag timestamp |
| ts_xlat_o | output | TS_W (32) | Address-translation timestamp |
| pulse_o | output | NUM_GEN (3) | One-cycle strobes, one per generator |

## Verification
The bench builds the block with LEGACY_MS_CYCLES set to 20, so the millisecond fallback advances many times in a short run. The base count, timestamp and divider widths keep their defaults. Divider fields from 0 to 9 combine with all four granularity codes, which brings both the first-pulse latency after enable and the steady pulse spacing into reach, up to the 10 ms code at a ratio of two. A ratio of one puts a timer tick on every cycle, so a granularity restart on one generator can be checked cycle-exactly against its untouched neighbours.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned SHIFT_W  = 6;
    localparam int unsigned GRAN_W   = 2;

    // field positions in the timestamp configuration word
    localparam int unsigned LOG_SHIFT_LSB  = 0;
    localparam int unsigned LOG_SEL_BIT    = 6;
    localparam int unsigned TAG_SHIFT_LSB  = 8;
    localparam int unsigned XLAT_SHIFT_LSB = 16;

    // enable bit in the divider word
    localparam int unsigned DIV_EN_BIT = 16;

    typedef enum logic [1:0] {
        ADDR_GRAN  = 2'd0,
        ADDR_TSCFG = 2'd1,
        ADDR_DIV   = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] log_shift;
        logic               log_sel;
        logic [SHIFT_W-1:0] tag_shift;
        logic [SHIFT_W-1:0] xlat_shift;
    } ts_cfg_t;

    // timer ticks per pulse for each granularity code (timer clock at 100 kHz)
    function automatic int unsigned gran_ticks(input logic [GRAN_W-1:0] code);
        int unsigned t;
        t = 1;
        for (int i = 0; i < int'(code); i++) begin
            t = t * 10;
        end
        return t;
    endfunction

    localparam int unsigned MAX_TICKS = 1000;

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned NUM_GEN = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [1:0]                     wr_addr_i,
    input  logic [REG_W-1:0]               wr_data_i,
    output ts_cfg_t                        ts_cfg_o,
    output logic [NUM_GEN-1:0][GRAN_W-1:0] gran_o,
    output logic [NUM_GEN-1:0]             restart_o,
    output logic [DIV_W-1:0]               div_m1_o,
    output logic                           div_en_o
);

    typedef struct packed {
        ts_cfg_t                        ts;
        logic [NUM_GEN-1:0][GRAN_W-1:0] gran;
        logic [DIV_W-1:0]               div_m1;
        logic                           div_en;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wdata;

    assign unused_wdata = ^wr_data_i;

    always_comb begin
        st_d      = st_q;
        restart_o = '0;
        if (wr_en_i && wr_addr_i == ADDR_TSCFG) begin
            st_d.ts.log_shift  = wr_data_i[LOG_SHIFT_LSB +: SHIFT_W];
            st_d.ts.log_sel    = wr_data_i[LOG_SEL_BIT];
            st_d.ts.tag_shift  = wr_data_i[TAG_SHIFT_LSB +: SHIFT_W];
            st_d.ts.xlat_shift = wr_data_i[XLAT_SHIFT_LSB +: SHIFT_W];
        end
        if (wr_en_i && wr_addr_i == ADDR_GRAN) begin
            for (int g = 0; g < int'(NUM_GEN); g++) begin
                st_d.gran[g] = wr_data_i[GRAN_W*g +: GRAN_W];
                restart_o[g] = (st_d.gran[g] != st_q.gran[g]);
            end
        end
        if (wr_en_i && wr_addr_i == ADDR_DIV) begin
            // ratio may only change while the divider is stopped
            if (!st_q.div_en) begin
                st_d.div_m1 = wr_data_i[DIV_W-1:0];
            end
            st_d.div_en = wr_data_i[DIV_EN_BIT];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ts_cfg_o = st_q.ts;
    assign gran_o   = st_q.gran;
    assign div_m1_o = st_q.div_m1;
    assign div_en_o = st_q.div_en;

endmodule

// File: rtl/tbase_divider.sv
module tbase_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] ratio_m1_i,
    output logic             tick_o,
    output logic [DIV_W-1:0] phase_o
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } div_t;

    div_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.phase == ratio_m1_i);

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.phase = '0;
        end else if (at_end) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o  = en_i && at_end;
    assign phase_o = st_q.phase;

endmodule

// File: rtl/tbase_pulse_gen.sv
module tbase_pulse_gen
    import tbase_pkg::*;
#(
    parameter int unsigned MAX_PERIOD = MAX_TICKS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [GRAN_W-1:0] gran_i,
    output logic              pulse_o
);

    localparam int unsigned CW = $clog2(MAX_PERIOD);

    typedef struct packed {
        logic [CW-1:0] count;
    } gen_t;

    gen_t          st_d, st_q;
    logic [CW-1:0] last;
    logic          at_last;

    assign last    = CW'(gran_ticks(gran_i) - 1);
    assign at_last = (st_q.count == last);

    always_comb begin
        st_d = st_q;
        if (!run_i || restart_i) begin
            st_d.count = '0;
        end else if (tick_i) begin
            st_d.count = at_last ? '0 : st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = tick_i && at_last;

endmodule

// File: rtl/timebase_gen.sv
module timebase_gen
    import tbase_pkg::*;
#(
    parameter int unsigned CNT_W            = 56,
    parameter int unsigned TS_W             = 32,
    parameter int unsigned DIV_W            = 8,
    parameter int unsigned NUM_GEN          = 3,
    parameter int unsigned LEGACY_MS_CYCLES = 19200
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [CNT_W-1:0]   base_count_o,
    output logic [TS_W-1:0]    ts_log_o,
    output logic [TS_W-1:0]    ts_tag_o,
    output logic [TS_W-1:0]    ts_xlat_o,
    output logic [NUM_GEN-1:0] pulse_o
);

    localparam int unsigned PRE_W = (LEGACY_MS_CYCLES > 1) ? $clog2(LEGACY_MS_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(LEGACY_MS_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic [TS_W-1:0]  ms;
    } base_t;

    base_t                          st_d, st_q;
    ts_cfg_t                        ts_cfg;
    logic [NUM_GEN-1:0][GRAN_W-1:0] gran;
    logic [NUM_GEN-1:0]             restart;
    logic [DIV_W-1:0]               div_m1;
    logic [DIV_W-1:0]               div_phase;
    logic                           div_en;
    logic                           timer_tick;

    tbase_regs #(
        .DIV_W   (DIV_W),
        .NUM_GEN (NUM_GEN)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ts_cfg_o  (ts_cfg),
        .gran_o    (gran),
        .restart_o (restart),
        .div_m1_o  (div_m1),
        .div_en_o  (div_en)
    );

    tbase_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (div_en),
        .ratio_m1_i (div_m1),
        .tick_o     (timer_tick),
        .phase_o    (div_phase)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        tbase_pulse_gen #(
            .MAX_PERIOD (MAX_TICKS)
        ) u_pgen (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .run_i     (div_en),
            .tick_i    (timer_tick),
            .restart_i (restart[g]),
            .gran_i    (gran[g]),
            .pulse_o   (pulse_o[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.pre == PRE_LAST) begin
            st_d.pre = '0;
            st_d.ms  = st_q.ms + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_count_o = st_q.cnt;
    assign ts_tag_o     = TS_W'(st_q.cnt >> ts_cfg.tag_shift);
    assign ts_xlat_o    = TS_W'(st_q.cnt >> ts_cfg.xlat_shift);
    assign ts_log_o     = ts_cfg.log_sel ? TS_W'(st_q.cnt >> ts_cfg.log_shift) : st_q.ms;

endmodule

// File: rtl/tbase_checker.sv
module tbase_checker #(
    parameter int unsigned CNT_W   = 56,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned NUM_GEN = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   base_cnt,
    input logic               div_en,
    input logic [DIV_W-1:0]   div_m1,
    input logic [DIV_W-1:0]   div_phase,
    input logic               timer_tick,
    input logic [NUM_GEN-1:0] pulse
);

    p_base_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> base_cnt == $past(base_cnt) + 1'b1);

    p_pulse_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |-> pulse == '0);

    p_pulse_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> timer_tick);

    p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_en) |-> div_phase == '0);

    p_ratio_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_en) && div_en) |-> div_m1 == $past(div_m1));

endmodule

bind timebase_gen tbase_checker #(
    .CNT_W   (CNT_W),
    .DIV_W   (DIV_W),
    .NUM_GEN (NUM_GEN)
) u_tbase_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .base_cnt   (base_count_o),
    .div_en     (div_en),
    .div_m1     (div_m1),
    .div_phase  (div_phase),
    .timer_tick (timer_tick),
    .pulse      (pulse_o)
);

// File: tb/timebase_gen_tb_top.sv
module timebase_gen_tb_top;

    localparam int unsigned CNT_W  = 56;
    localparam int unsigned TS_W   = 32;
    localparam int unsigned LEGACY = 20;
    localparam int unsigned NG     = 3;

    // vector: divider field, gran0, gran1, gran2
    localparam int NV = 6;
    localparam logic [13:0] VEC [NV] = '{
        {8'd0, 2'd0, 2'd1, 2'd2},
        {8'd3, 2'd1, 2'd2, 2'd0},
        {8'd4, 2'd2, 2'd0, 2'd1},
        {8'd1, 2'd3, 2'd0, 2'd0},
        {8'd9, 2'd1, 2'd1, 2'd1},
        {8'd0, 2'd3, 2'd3, 2'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [CNT_W-1:0]  base_count;
    logic [TS_W-1:0]   ts_log, ts_tag, ts_xlat;
    logic [NG-1:0]     pulse;

    int checks = 0;
    int failures = 0;
    int k = 0;
    int first_k [NG];
    int second_k [NG];
    bit done = 1'b0;

    always #4 clk = ~clk;

    timebase_gen #(
        .CNT_W            (CNT_W),
        .TS_W             (TS_W),
        .LEGACY_MS_CYCLES (LEGACY)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .base_count_o (base_count),
        .ts_log_o     (ts_log),
        .ts_tag_o     (ts_tag),
        .ts_xlat_o    (ts_xlat),
        .pulse_o      (pulse)
    );

    function automatic int ticks_of(input int code);
        case (code)
            0: return 1;
            1: return 10;
            2: return 100;
            default: return 1000;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        for (int g = 0; g < NG; g++) begin
            first_k[g]  = 0;
            second_k[g] = 0;
        end
    endtask

    task automatic sample_pulses();
        for (int g = 0; g < NG; g++) begin
            if (pulse[g]) begin
                if (first_k[g] == 0) first_k[g] = k;
                else if (second_k[g] == 0) second_k[g] = k;
            end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k++;
            sample_pulses();
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        k++;
        sample_pulses();
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] gran_word(input int g0, input int g1, input int g2);
        return 32'(g0) | (32'(g1) << 2) | (32'(g2) << 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state (R10, R1, R6)
        repeat (3) @(negedge clk);
        check("R1 reset base", longint'(base_count), 0);
        check("R6 reset pulses", longint'(pulse), 0);
        check("R10 reset tag ts", longint'(ts_tag), 0);
        check("R10 reset log ts", longint'(ts_log), 0);
        rst_n = 1'b1;

        // R1: base count advances by one per cycle
        begin
            longint b0;
            step(5);
            b0 = longint'(base_count);
            check("R1 count after release", b0, 5);
            step(7);
            check("R1 count step", longint'(base_count), b0 + 7);
        end

        // R10: default shifts zero, log select zero; R3 legacy ms source
        for (int i = 0; i < 3; i++) begin
            step(17);
            check("R10 tag shift zero", longint'(ts_tag), longint'(base_count));
            check("R10 xlat shift zero", longint'(ts_xlat), longint'(base_count));
            check("R3 legacy ms count", longint'(ts_log), longint'(base_count / LEGACY));
        end

        // R6: no pulses while divider disabled after reset
        clear_rec();
        step(30);
        for (int g = 0; g < NG; g++) check("R6 idle pulses", first_k[g], 0);

        // R2, R3: shifted timestamps
        reg_write(2'd1, 32'd5 | (32'd1 << 6) | (32'd3 << 8) | (32'd10 << 16));
        for (int i = 0; i < 3; i++) begin
            step(41);
            check("R2 tag ts", longint'(ts_tag), longint'(TS_W'(base_count >> 3)));
            check("R2 xlat ts", longint'(ts_xlat), longint'(TS_W'(base_count >> 10)));
            check("R3 log ts shifted", longint'(ts_log), longint'(TS_W'(base_count >> 5)));
        end
        reg_write(2'd1, 32'd0 | (32'd63 << 8) | (32'd1 << 16));
        step(3);
        check("R2 tag large shift", longint'(ts_tag), 0);
        check("R2 xlat shift one", longint'(ts_xlat), longint'(TS_W'(base_count >> 1)));
        check("R3 log back to ms", longint'(ts_log), longint'(base_count / LEGACY));

        // R4, R5, R7: vector walk
        for (int v = 0; v < NV; v++) begin
            int dv, n, maxp;
            int gr [NG];
            dv    = int'(VEC[v][13:6]);
            gr[0] = int'(VEC[v][5:4]);
            gr[1] = int'(VEC[v][3:2]);
            gr[2] = int'(VEC[v][1:0]);
            n     = dv + 1;
            reg_write(2'd2, 32'(dv));
            reg_write(2'd0, gran_word(gr[0], gr[1], gr[2]));
            reg_write(2'd2, 32'(dv) | (32'd1 << 16));
            k = 0;
            clear_rec();
            maxp = 0;
            for (int g = 0; g < NG; g++)
                if (n * ticks_of(gr[g]) > maxp) maxp = n * ticks_of(gr[g]);
            step(2 * maxp + 2);
            for (int g = 0; g < NG; g++) begin
                check("R7 first pulse after enable", first_k[g], n * ticks_of(gr[g]));
                check("R5 second pulse R4 timer ratio", second_k[g], 2 * n * ticks_of(gr[g]));
            end
            reg_write(2'd2, 32'(dv));
        end

        // R9: granularity change restarts only the changed generator
        reg_write(2'd2, 32'd0);
        reg_write(2'd0, gran_word(1, 1, 1));
        reg_write(2'd2, 32'd0 | (32'd1 << 16));
        k = 0;
        clear_rec();
        step(4);
        reg_write(2'd0, gran_word(2, 1, 1));
        step(110 - k);
        check("R9 restarted gen first", first_k[0], 105);
        check("R9 untouched gen first", first_k[1], 10);
        check("R9 untouched gen second", second_k[2], 20);

        // R8: ratio write while enabled is ignored
        reg_write(2'd2, 32'd0);
        reg_write(2'd0, gran_word(0, 0, 0));
        reg_write(2'd2, 32'd1 | (32'd1 << 16));
        k = 0;
        step(3);
        reg_write(2'd2, 32'd5 | (32'd1 << 16));
        clear_rec();
        step(12 - k);
        check("R8 ratio kept first", first_k[0], 6);
        check("R8 ratio kept second", second_k[0], 8);

        // R6: disabling stops all pulses
        reg_write(2'd2, 32'd1);
        clear_rec();
        step(30);
        for (int g = 0; g < NG; g++) check("R6 disabled pulses", first_k[g], 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule